// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers five interrupt requests for a small processor core and turns them into a single request line with a program-memory vector. Two of the requests come from active-low external pins, two from timer overflow flags and one from a serial port flag. Each request passes a per-source enable and one global enable. A per-source priority bit then places it at the high or the low level. Inside a level, a fixed polling order breaks ties between simultaneous requests.

The winning request is registered and presented as `irq` together with its vector address. The core accepts it with a one-cycle `ack` strobe. The block answers with a one-hot strobe naming the accepted source, so that the timer and serial logic can clear their own flags. The block remembers which levels have a handler in progress, so that only a high-level request can interrupt a low-level handler. A one-cycle `reti` pulse from the core closes the innermost handler.

Each external pin can be set to level sensing, where the request follows the pin, or to edge sensing, where a falling edge sets a latched flag that clears when that source is acknowledged.

Top module: `intc_two_level`

## Requirements
- R1: After reset, `irq` is 0, `vec_addr` is 0, `ack_src` is 0 and no handler level is active, so a single enabled request is presented without any `reti`.
- R2: A request is considered only while its own `src_en` bit and `glb_en` are both 1; if either is 0, that request never raises `irq`.
- R3: Among eligible requests of one level, the winner is the lowest source index. Source indices are 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial.
- R4: `vec_addr` is 0x0003 + 8 × (source index) of the presented source, so the five vectors are 0x03, 0x0B, 0x13, 0x1B and 0x23. `vec_addr` is 0 whenever `irq` is 0.
- R5: When no handler is active, an eligible request whose `prio_hi` bit is 1 wins over any request whose `prio_hi` bit is 0.
- R6: While a low-level handler is active, low-level requests are held pending (`irq` stays 0) and a high-level request is still presented. Pending low requests are presented once `reti` has closed the low handler.
- R7: While a high-level handler is active, no request is presented. `reti` closes the high handler first; a second `reti` closes the low handler beneath it.
- R8: With `ext_edge` set for a pin, a high-to-low transition seen on two consecutive clock samples latches a request that stays after the pin returns high. Acknowledging that source clears it, and a pin held low does not set it again.
- R9: With `ext_edge` clear for a pin, the request is the inverted, sampled pin level and is not latched: once the pin returns high, `irq` falls.
- R10: `ack` while `irq` is 1 accepts the presented source: `ack_src` is one-hot on that source during the `ack` cycle, and `irq` is 0 in the following cycle. A request that appears in the `ack` cycle does not change which source is accepted.
- R11: `ack` while `irq` is 0 has no effect: `ack_src` stays 0 and no level becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_n | input | 2 | External request pins, active low |
| tmr_flag | input | 2 | Timer overflow flags |
| ser_flag | input | 1 | Serial port flag |
| src_en | input | 5 | Per-source enables, by source index |
| glb_en | input | 1 | Global enable |
| prio_hi | input | 5 | Per-source level select, 1 = high level |
| ext_edge | input | 2 | Per-pin sensing, 1 = falling edge, 0 = level |
| ack | input | 1 | Core accepts the presented vector |
| reti | input | 1 | Core returns from the innermost handler |
| irq | output | 1 | Request to the core |
| vec_addr | output | 16 | Vector address of the presented source |
| ack_src | output | 5 | One-hot accepted source, valid in the ack cycle |

## Verification
The bench builds nesting stacks on purpose. A controller that lets a same-level request interrupt a handler would vector a second low request inside the first one. A controller whose `reti` pops the wrong level would release low requests while a high handler still runs. It raises a high request exactly in the `ack` cycle of a low one: a design that arbitrates in that cycle would report the wrong source in `ack_src` or vector twice. It pulses and holds the external pins in both sensing modes, which catches an edge flag that never clears, one that re-arms on a held-low pin, and a level request that wrongly latches.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NSRC    = 5;
    localparam int NEXT    = 2;
    localparam int IDX_W   = $clog2(NSRC);

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4
    } src_id_e;

    typedef struct packed {
        logic pin_q;
        logic pin_qq;
        logic flag;
    } sense_t;

    function automatic int ext_src_idx(input int pin);
        return (pin == 0) ? int'(SRC_EXT0) : int'(SRC_EXT1);
    endfunction

endpackage

// File: rtl/intc_ext_sense.sv
module intc_ext_sense
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);

    sense_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.pin_q  = pin_n;
        s_d.pin_qq = s_q.pin_q;
        if (!edge_mode) begin
            s_d.flag = 1'b0;
        end else if (s_q.pin_qq && !s_q.pin_q) begin
            s_d.flag = 1'b1;
        end else if (clr) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{pin_q: 1'b1, pin_qq: 1'b1, flag: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req = edge_mode ? s_q.flag : ~s_q.pin_q;

endmodule

// File: rtl/intc_first_pick.sv
module intc_first_pick #(
    parameter int N     = 5,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [N-1:0]     onehot,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        valid  = 1'b0;
        onehot = '0;
        idx    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid  = 1'b1;
                onehot = '0;
                onehot[i] = 1'b1;
                idx    = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
    import intc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NEXT-1:0]   ext_pin_n,
    input  logic [1:0]        tmr_flag,
    input  logic              ser_flag,
    input  logic [NSRC-1:0]   src_en,
    input  logic              glb_en,
    input  logic [NSRC-1:0]   prio_hi,
    input  logic [NEXT-1:0]   ext_edge,
    input  logic              ack,
    input  logic              reti,
    output logic              irq,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [NSRC-1:0]   ack_src
);

    typedef struct packed {
        logic              in_hi;
        logic              in_lo;
        logic              irq;
        logic              irq_hi;
        logic [NSRC-1:0]   win;
        logic [ADDR_W-1:0] vec;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [NEXT-1:0]  ext_req;
    logic [NSRC-1:0]  req_all;
    logic [NSRC-1:0]  armed;
    logic [NSRC-1:0]  hi_set, lo_set;
    logic             hi_valid, lo_valid;
    logic [NSRC-1:0]  hi_oh, lo_oh;
    logic [IDX_W-1:0] hi_idx, lo_idx;
    logic             accept;

    assign accept = ack & s_q.irq;

    for (genvar j = 0; j < NEXT; j++) begin : g_ext
        localparam int SI = ext_src_idx(j);
        intc_ext_sense u_sense (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_pin_n[j]),
            .edge_mode (ext_edge[j]),
            .clr       (accept & s_q.win[SI]),
            .req       (ext_req[j])
        );
    end

    always_comb begin
        req_all           = '0;
        req_all[SRC_EXT0] = ext_req[0];
        req_all[SRC_TMR0] = tmr_flag[0];
        req_all[SRC_EXT1] = ext_req[1];
        req_all[SRC_TMR1] = tmr_flag[1];
        req_all[SRC_SER]  = ser_flag;
    end

    assign armed  = req_all & src_en & {NSRC{glb_en}};
    assign hi_set = armed &  prio_hi & {NSRC{~s_q.in_hi}};
    assign lo_set = armed & ~prio_hi & {NSRC{~s_q.in_hi & ~s_q.in_lo}};

    intc_first_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick_hi (
        .req    (hi_set),
        .valid  (hi_valid),
        .onehot (hi_oh),
        .idx    (hi_idx)
    );

    intc_first_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick_lo (
        .req    (lo_set),
        .valid  (lo_valid),
        .onehot (lo_oh),
        .idx    (lo_idx)
    );

    always_comb begin
        s_d = s_q;
        if (accept) begin
            if (s_q.irq_hi) begin
                s_d.in_hi = 1'b1;
            end else begin
                s_d.in_lo = 1'b1;
            end
            s_d.irq    = 1'b0;
            s_d.irq_hi = 1'b0;
            s_d.win    = '0;
            s_d.vec    = '0;
        end else begin
            if (reti) begin
                if (s_q.in_hi) begin
                    s_d.in_hi = 1'b0;
                end else begin
                    s_d.in_lo = 1'b0;
                end
            end
            s_d.irq    = hi_valid | lo_valid;
            s_d.irq_hi = hi_valid;
            if (hi_valid) begin
                s_d.win = hi_oh;
                s_d.vec = ADDR_W'(VEC_BASE + VEC_STRIDE * int'(hi_idx));
            end else if (lo_valid) begin
                s_d.win = lo_oh;
                s_d.vec = ADDR_W'(VEC_BASE + VEC_STRIDE * int'(lo_idx));
            end else begin
                s_d.win = '0;
                s_d.vec = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq      = s_q.irq;
    assign vec_addr = s_q.vec;
    assign ack_src  = accept ? s_q.win : '0;

endmodule

// File: rtl/intc_two_level_chk.sv
module intc_two_level_chk #(
    parameter int ADDR_W     = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8,
    parameter int NSRC       = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glb_en,
    input logic              ack,
    input logic              irq,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [NSRC-1:0]   ack_src
);

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_src)); // R10

    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq) |=> !irq); // R10

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (ack_src == '0)); // R11

    AST_VEC_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (vec_addr == '0)); // R4

    AST_VEC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((int'(vec_addr) - VEC_BASE) % VEC_STRIDE == 0)); // R4

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !irq); // R2

endmodule

bind intc_two_level intc_two_level_chk #(
    .ADDR_W     (ADDR_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE),
    .NSRC       (intc_pkg::NSRC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .glb_en   (glb_en),
    .ack      (ack),
    .irq      (irq),
    .vec_addr (vec_addr),
    .ack_src  (ack_src)
);

// File: tb/intc_two_level_test.sv
module intc_two_level_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  tmr_flag = 2'b00;
    logic        ser_flag = 1'b0;
    logic [4:0]  src_en = 5'b11111;
    logic        glb_en = 1'b1;
    logic [4:0]  prio_hi = 5'b00000;
    logic [1:0]  ext_edge = 2'b00;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic        irq;
    logic [15:0] vec_addr;
    logic [4:0]  ack_src;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    intc_two_level uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin_n (ext_pin_n),
        .tmr_flag  (tmr_flag),
        .ser_flag  (ser_flag),
        .src_en    (src_en),
        .glb_en    (glb_en),
        .prio_hi   (prio_hi),
        .ext_edge  (ext_edge),
        .ack       (ack),
        .reti      (reti),
        .irq       (irq),
        .vec_addr  (vec_addr),
        .ack_src   (ack_src)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic expect_irq(input string tag, input logic [15:0] v);
        check({tag, " irq"}, {31'd0, irq}, 32'd1);
        check({tag, " vec"}, {16'd0, vec_addr}, {16'd0, v});
    endtask

    task automatic expect_quiet(input string tag);
        check({tag, " irq low"}, {31'd0, irq}, 32'd0);
    endtask

    task automatic do_ack(input string tag, input logic [4:0] exp_src);
        ack = 1'b1;
        #1;
        check({tag, " ack_src"}, {27'd0, ack_src}, {27'd0, exp_src});
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1;
        tick(1);
        reti = 1'b0;
        tick(1);
    endtask

    task automatic idle_all();
        ext_pin_n = 2'b11;
        tmr_flag  = 2'b00;
        ser_flag  = 1'b0;
        prio_hi   = 5'b00000;
        ext_edge  = 2'b00;
        src_en    = 5'b11111;
        glb_en    = 1'b1;
        pulse_reti();
        pulse_reti();
        tick(3);
    endtask

    task automatic t_reset();
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        check("R1 vec after reset", {16'd0, vec_addr}, 32'd0);
        check("R1 ack_src after reset", {27'd0, ack_src}, 32'd0);
        tmr_flag[1] = 1'b1;
        tick(1);
        expect_irq("R1 no level active", 16'h001B);
        idle_all();
    endtask

    task automatic t_vectors();
        for (int i = 0; i < 5; i++) begin
            case (i)
                0: ext_pin_n[0] = 1'b0;
                1: tmr_flag[0]  = 1'b1;
                2: ext_pin_n[1] = 1'b0;
                3: tmr_flag[1]  = 1'b1;
                default: ser_flag = 1'b1;
            endcase
            tick(3);
            expect_irq("R4 vector", 16'(3 + 8 * i));
            ext_pin_n = 2'b11;
            tmr_flag  = 2'b00;
            ser_flag  = 1'b0;
            tick(3);
            expect_quiet("R4 idle vector");
            check("R4 vec zero idle", {16'd0, vec_addr}, 32'd0);
        end
    endtask

    task automatic t_order();
        tmr_flag = 2'b11;
        ser_flag = 1'b1;
        tick(1);
        expect_irq("R3 timer0 first", 16'h000B);
        tmr_flag[0]  = 1'b0;
        ext_pin_n[1] = 1'b0;
        tick(3);
        expect_irq("R3 ext1 before timer1", 16'h0013);
        ext_pin_n[1] = 1'b1;
        tick(3);
        expect_irq("R3 timer1 before serial", 16'h001B);
        idle_all();
    endtask

    task automatic t_gating();
        tmr_flag[0] = 1'b1;
        glb_en = 1'b0;
        tick(2);
        expect_quiet("R2 global off");
        glb_en = 1'b1;
        src_en[1] = 1'b0;
        tick(2);
        expect_quiet("R2 source off");
        src_en[1] = 1'b1;
        tick(1);
        expect_irq("R2 both on", 16'h000B);
        idle_all();
    endtask

    task automatic t_prio();
        tmr_flag[0] = 1'b1;
        ser_flag = 1'b1;
        prio_hi[4] = 1'b1;
        tick(1);
        expect_irq("R5 high level wins", 16'h0023);
        idle_all();
    endtask

    task automatic t_nest();
        tmr_flag[0] = 1'b1;
        tick(1);
        expect_irq("R6 low presented", 16'h000B);
        do_ack("R10 low accept", 5'b00010);
        tmr_flag[0] = 1'b0;
        expect_quiet("R10 drop after ack");
        tmr_flag[1] = 1'b1;
        tick(2);
        expect_quiet("R6 same level held");
        prio_hi[4] = 1'b1;
        ser_flag = 1'b1;
        tick(1);
        expect_irq("R6 high preempts low", 16'h0023);
        do_ack("R6 high accept", 5'b10000);
        ser_flag = 1'b0;
        prio_hi[1] = 1'b1;
        tmr_flag[0] = 1'b1;
        tick(2);
        expect_quiet("R7 nothing preempts high");
        pulse_reti();
        expect_irq("R7 reti pops high", 16'h000B);
        do_ack("R7 high again", 5'b00010);
        tmr_flag[0] = 1'b0;
        pulse_reti();
        expect_quiet("R6 low still active");
        pulse_reti();
        expect_irq("R6 pending low released", 16'h001B);
        do_ack("R6 low accept", 5'b01000);
        idle_all();
    endtask

    task automatic t_ack_cycle();
        tmr_flag[0] = 1'b1;
        tick(1);
        expect_irq("R10 low presented", 16'h000B);
        prio_hi[4] = 1'b1;
        ser_flag = 1'b1;
        do_ack("R10 late request ignored", 5'b00010);
        tmr_flag[0] = 1'b0;
        expect_quiet("R10 gap cycle");
        tick(1);
        expect_irq("R10 late request served next", 16'h0023);
        do_ack("R10 serial accept", 5'b10000);
        idle_all();
    endtask

    task automatic t_idle_ack();
        expect_quiet("R11 start idle");
        do_ack("R11 ack with no irq", 5'b00000);
        tmr_flag[1] = 1'b1;
        tick(1);
        expect_irq("R11 no level taken", 16'h001B);
        idle_all();
    endtask

    task automatic t_edge();
        ext_edge[0] = 1'b1;
        tick(2);
        ext_pin_n[0] = 1'b0;
        tick(1);
        ext_pin_n[0] = 1'b1;
        tick(3);
        expect_irq("R8 edge latched", 16'h0003);
        do_ack("R8 edge accept", 5'b00001);
        pulse_reti();
        tick(1);
        expect_quiet("R8 flag cleared by ack");
        ext_pin_n[0] = 1'b0;
        tick(4);
        expect_irq("R8 held low sets once", 16'h0003);
        do_ack("R8 second accept", 5'b00001);
        pulse_reti();
        tick(2);
        expect_quiet("R8 held low no retrigger");
        idle_all();
    endtask

    task automatic t_level();
        ext_pin_n[1] = 1'b0;
        tick(2);
        expect_irq("R9 level follows pin", 16'h0013);
        ext_pin_n[1] = 1'b1;
        tick(2);
        expect_quiet("R9 level not latched");
        idle_all();
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_vectors();
        t_order();
        t_gating();
        t_prio();
        t_nest();
        t_ack_cycle();
        t_idle_ack();
        t_edge();
        t_level();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule